// File: doc/BRIEF.md
# Seconds/Nanoseconds Time-of-Day Clock with Sub-Nanosecond Residue

This block keeps wall-clock time as a seconds count, a nanoseconds count and a 32-bit fraction of a nanosecond. It runs on a reference clock of fixed frequency. Each cycle it advances by a nominal 12.5 ns. A signed fine correction, expressed in units of 2^-32 ns, is added to or taken from that nominal amount. Carries from the fraction reach the nanoseconds. When the nanoseconds pass the end of a second, the count wraps and the seconds count moves up in the same cycle.

Software uses a small word-wide register port. It reads any of the time words and the correction word, and it writes the correction and a new time. A new time is written as a seconds value staged in two words, then committed by a write of the nanoseconds. A pulse-per-second level output is high for the first half of every second and low for the second half.

Top module: `sns_tod_clock`

## Requirements
- R1: After reset the nanoseconds, residue, seconds and correction words all read zero, and the pulse output is high.
- R2: With a zero correction word, each cycle adds 0x80000000 to the residue and 12 to the nanoseconds, plus 1 more nanosecond when the residue sum carries out of 32 bits. Two cycles from reset therefore give 25 ns.
- R3: The correction word is sign-magnitude. When bit 31 is 0, bits 30:0 are added to the 0x80000000 residue increment. When bit 31 is 1, they are subtracted from it. The per-cycle nanosecond step is therefore always 12 or 13.
- R4: A write to address 4 loads the correction word. It is read back at address 4 and first affects the step of the following cycle.
- R5: When nanoseconds plus the step reach the one-second limit, the limit is subtracted and the seconds count increments in that same cycle.
- R6: The seconds count is wider than one data word and carries across words. Address 2 reads bits 31:0 and address 3 reads the upper bits, zero-extended.
- R7: Writes to address 2 (low) and address 3 (high) only stage a seconds value. The live seconds count and the stepping of time are unaffected.
- R8: A write to address 0 loads the written nanoseconds, loads the staged seconds and clears the residue. The new time appears after that edge, and no step is added in that cycle.
- R9: The pulse output is high while nanoseconds are below the half-second value and low otherwise.
- R10: Address 1 reads the residue. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-rate reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| pps | output | 1 | Pulse-per-second level |

## Verification
The bench builds the block with a one-second limit of 1000 ns, a half-second of 500 ns, a 10-bit nanoseconds field and 40-bit seconds. At these settings a full second passes in about 80 reference cycles, so second rollovers, repeated pulse edges and the carry from the low seconds word into the high word are all reached within a short run. The positive and negative extremes of the correction word are applied, which brings both the 13 ns and the 12 ns steps within reach. A time commit is also placed just ahead of a rollover.

// File: rtl/sns_tod_pkg.sv
package sns_tod_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_NS     = 3'd0,
      REG_RES    = 3'd1,
      REG_SEC_LO = 3'd2,
      REG_SEC_HI = 3'd3,
      REG_ADJ    = 3'd4
   } tod_reg_e;
endpackage

// File: rtl/sns_tod_frac_step.sv
// Converts the sign-magnitude correction word into the per-cycle residue increment.
module sns_tod_frac_step #(
   parameter int unsigned FRAC_W = 32
) (
   input  logic [FRAC_W-1:0] adj_word,
   output logic [FRAC_W-1:0] frac_inc
);
   localparam int unsigned MAG_W = FRAC_W - 1;
   localparam logic [FRAC_W-1:0] NOM_FRAC = {1'b1, {MAG_W{1'b0}}};

   logic [FRAC_W-1:0] mag_ext;
   logic              neg;

   assign mag_ext = {1'b0, adj_word[MAG_W-1:0]};
   assign neg     = adj_word[FRAC_W-1];

   // Nominal half-nanosecond plus or minus the magnitude; never wraps.
   always_comb begin
      if (neg) frac_inc = NOM_FRAC - mag_ext;
      else     frac_inc = NOM_FRAC + mag_ext;
   end
endmodule

// File: rtl/sns_tod_residue.sv
// Sub-nanosecond accumulator; its carry adds one nanosecond.
module sns_tod_residue #(
   parameter int unsigned FRAC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [FRAC_W-1:0] frac_inc,
   output logic [FRAC_W-1:0] res_q,
   output logic              carry
);
   logic [FRAC_W:0] sum;

   assign sum   = {1'b0, res_q} + {1'b0, frac_inc};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res_q <= '0;
      else if (clear) res_q <= '0;
      else            res_q <= sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/sns_tod_ns_sec.sv
// Nanoseconds and seconds registers with end-of-second wrap and load.
module sns_tod_ns_sec #(
   parameter int unsigned NS_W       = 30,
   parameter int unsigned SEC_W      = 48,
   parameter int unsigned NOM_NS     = 12,
   parameter int unsigned NS_PER_SEC = 1000000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NS_W-1:0]  load_ns,
   input  logic [SEC_W-1:0] load_sec,
   input  logic             carry_in,
   output logic [NS_W-1:0]  ns_q,
   output logic [NS_W-1:0]  ns_d,
   output logic [SEC_W-1:0] sec_q
);
   localparam logic [NS_W:0] LIMIT = (NS_W+1)'(NS_PER_SEC);
   localparam logic [NS_W:0] BASE  = (NS_W+1)'(NOM_NS);

   logic [NS_W:0]    adv;
   logic [NS_W:0]    adv_wrapped;
   logic             wrap;
   logic [SEC_W-1:0] sec_d;

   assign adv         = {1'b0, ns_q} + BASE + {{NS_W{1'b0}}, carry_in};
   assign wrap        = (adv >= LIMIT);
   assign adv_wrapped = adv - LIMIT;

   always_comb begin
      if (load) begin
         ns_d  = load_ns;
         sec_d = load_sec;
      end else if (wrap) begin
         ns_d  = adv_wrapped[NS_W-1:0];
         sec_d = sec_q + SEC_W'(1);
      end else begin
         ns_d  = adv[NS_W-1:0];
         sec_d = sec_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns_q  <= '0;
         sec_q <= '0;
      end else begin
         ns_q  <= ns_d;
         sec_q <= sec_d;
      end
   end
endmodule

// File: rtl/sns_tod_pps.sv
// Half-second level generator, registered from next-state or decoded from state.
module sns_tod_pps #(
   parameter int unsigned NS_W     = 30,
   parameter int unsigned HALF_SEC = 500000000,
   parameter bit          PPS_REG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NS_W-1:0] ns_cur,
   input  logic [NS_W-1:0] ns_nxt,
   output logic            pps
);
   localparam logic [NS_W-1:0] HALF_V = NS_W'(HALF_SEC);

   generate
      if (PPS_REG) begin : g_reg
         logic pps_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pps_r <= 1'b1;
            else        pps_r <= (ns_nxt < HALF_V);
         end
         assign pps = pps_r;
         logic unused_cur;
         assign unused_cur = ^ns_cur;
      end else begin : g_comb
         assign pps = (ns_cur < HALF_V);
         logic unused_nxt;
         assign unused_nxt = ^{clk, rst_n, ns_nxt};
      end
   endgenerate
endmodule

// File: rtl/sns_tod_regif.sv
// Register decode: correction word, staged seconds, commit strobe, read mux.
module sns_tod_regif
   import sns_tod_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NS_W   = 30,
   parameter int unsigned SEC_W  = 48,
   parameter int unsigned FRAC_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   input  logic [NS_W-1:0]       ns_q,
   input  logic [FRAC_W-1:0]     res_q,
   input  logic [SEC_W-1:0]      sec_q,
   output logic [FRAC_W-1:0]     adj_q,
   output logic [SEC_W-1:0]      stage_sec,
   output logic                  commit,
   output logic [NS_W-1:0]       commit_ns,
   output logic [DATA_W-1:0]     rd_data
);
   localparam int unsigned HI_W = SEC_W - DATA_W;

   logic [DATA_W-1:0] stage_lo;
   logic [HI_W-1:0]   stage_hi;
   logic              wr_adj, wr_lo, wr_hi;

   assign commit    = wr_en && (wr_addr == REG_NS);
   assign wr_adj    = wr_en && (wr_addr == REG_ADJ);
   assign wr_lo     = wr_en && (wr_addr == REG_SEC_LO);
   assign wr_hi     = wr_en && (wr_addr == REG_SEC_HI);
   assign commit_ns = wr_data[NS_W-1:0];
   assign stage_sec = {stage_hi, stage_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q    <= '0;
         stage_lo <= '0;
         stage_hi <= '0;
      end else begin
         if (wr_adj) adj_q    <= wr_data[FRAC_W-1:0];
         if (wr_lo)  stage_lo <= wr_data;
         if (wr_hi)  stage_hi <= wr_data[HI_W-1:0];
      end
   end

   always_comb begin
      case (rd_addr)
         REG_NS:     rd_data = DATA_W'(ns_q);
         REG_RES:    rd_data = DATA_W'(res_q);
         REG_SEC_LO: rd_data = sec_q[DATA_W-1:0];
         REG_SEC_HI: rd_data = DATA_W'(sec_q[SEC_W-1:DATA_W]);
         REG_ADJ:    rd_data = DATA_W'(adj_q);
         default:    rd_data = '0;
      endcase
   end

   logic unused_wd;
   assign unused_wd = ^wr_data;
endmodule

// File: rtl/sns_tod_clock.sv
// Top: fixed 12.5 ns step with sign-magnitude fractional correction.
module sns_tod_clock
   import sns_tod_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FRAC_W     = 32,
   parameter int unsigned NS_W       = 30,
   parameter int unsigned SEC_W      = 48,
   parameter int unsigned NOM_NS     = 12,
   parameter int unsigned NS_PER_SEC = 1000000000,
   parameter int unsigned HALF_SEC   = 500000000,
   parameter bit          PPS_REG    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  pps
);
   localparam longint unsigned NS_SPAN = longint'(1) << NS_W;

   generate
      if (FRAC_W != DATA_W) begin : g_bad_frac
         $error("FRAC_W must equal DATA_W");
      end
      if (NS_W > DATA_W) begin : g_bad_nsw
         $error("NS_W must fit in one data word");
      end
      if (SEC_W <= DATA_W || SEC_W > 2*DATA_W) begin : g_bad_secw
         $error("SEC_W must span more than one and at most two data words");
      end
      if (longint'(NS_PER_SEC) + longint'(NOM_NS) + 1 >= NS_SPAN) begin : g_bad_lim
         $error("NS_W too narrow for NS_PER_SEC");
      end
      if (HALF_SEC == 0 || HALF_SEC >= NS_PER_SEC) begin : g_bad_half
         $error("HALF_SEC must lie inside one second");
      end
      if (NOM_NS + 1 >= NS_PER_SEC) begin : g_bad_step
         $error("step must be shorter than one second");
      end
   endgenerate

   logic [FRAC_W-1:0] adj_q;
   logic [FRAC_W-1:0] frac_inc;
   logic [FRAC_W-1:0] res_q;
   logic              res_carry;
   logic [NS_W-1:0]   ns_q;
   logic [NS_W-1:0]   ns_d;
   logic [SEC_W-1:0]  sec_q;
   logic [SEC_W-1:0]  stage_sec;
   logic [NS_W-1:0]   commit_ns;
   logic              commit;

   sns_tod_regif #(
      .DATA_W (DATA_W), .NS_W (NS_W), .SEC_W (SEC_W), .FRAC_W (FRAC_W)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .ns_q      (ns_q),
      .res_q     (res_q),
      .sec_q     (sec_q),
      .adj_q     (adj_q),
      .stage_sec (stage_sec),
      .commit    (commit),
      .commit_ns (commit_ns),
      .rd_data   (rd_data)
   );

   sns_tod_frac_step #(.FRAC_W (FRAC_W)) u_step (
      .adj_word (adj_q),
      .frac_inc (frac_inc)
   );

   sns_tod_residue #(.FRAC_W (FRAC_W)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (commit),
      .frac_inc (frac_inc),
      .res_q    (res_q),
      .carry    (res_carry)
   );

   sns_tod_ns_sec #(
      .NS_W (NS_W), .SEC_W (SEC_W), .NOM_NS (NOM_NS), .NS_PER_SEC (NS_PER_SEC)
   ) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (commit),
      .load_ns  (commit_ns),
      .load_sec (stage_sec),
      .carry_in (res_carry),
      .ns_q     (ns_q),
      .ns_d     (ns_d),
      .sec_q    (sec_q)
   );

   sns_tod_pps #(
      .NS_W (NS_W), .HALF_SEC (HALF_SEC), .PPS_REG (PPS_REG)
   ) u_pps (
      .clk    (clk),
      .rst_n  (rst_n),
      .ns_cur (ns_q),
      .ns_nxt (ns_d),
      .pps    (pps)
   );
endmodule

// File: rtl/sns_tod_chk.sv
module sns_tod_chk #(
   parameter int unsigned NS_W       = 30,
   parameter int unsigned SEC_W      = 48,
   parameter int unsigned FRAC_W     = 32,
   parameter int unsigned NOM_NS     = 12,
   parameter int unsigned NS_PER_SEC = 1000000000,
   parameter int unsigned HALF_SEC   = 500000000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [NS_W-1:0]   ns_q,
   input logic [FRAC_W-1:0] res_q,
   input logic [SEC_W-1:0]  sec_q,
   input logic              pps
);
   localparam logic [NS_W-1:0] LIM  = NS_W'(NS_PER_SEC);
   localparam logic [NS_W-1:0] HALF = NS_W'(HALF_SEC);
   localparam logic [NS_W-1:0] S_LO = NS_W'(NOM_NS);
   localparam logic [NS_W-1:0] S_HI = NS_W'(NOM_NS + 1);

   logic seen, commit_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen        <= 1'b0;
         commit_prev <= 1'b0;
      end else begin
         seen        <= 1'b1;
         commit_prev <= wr_en && (wr_addr == 3'd0);
      end
   end

   AST_NS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !commit_prev && ($past(ns_q) < LIM) |-> ns_q < LIM); // R5
   AST_STEP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !commit_prev && (ns_q >= $past(ns_q)) |->
         ((ns_q - $past(ns_q)) == S_LO || (ns_q - $past(ns_q)) == S_HI)); // R3
   AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !commit_prev && (ns_q < $past(ns_q)) |-> sec_q == $past(sec_q) + SEC_W'(1)); // R5
   AST_SEC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !commit_prev && (ns_q >= $past(ns_q)) |-> sec_q == $past(sec_q)); // R7
   AST_COMMIT_CLEARS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      seen && commit_prev |-> res_q == '0); // R8
   AST_PPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> pps == (ns_q < HALF)); // R9
endmodule

bind sns_tod_clock sns_tod_chk #(
   .NS_W (NS_W), .SEC_W (SEC_W), .FRAC_W (FRAC_W), .NOM_NS (NOM_NS),
   .NS_PER_SEC (NS_PER_SEC), .HALF_SEC (HALF_SEC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .ns_q    (ns_q),
   .res_q   (res_q),
   .sec_q   (sec_q),
   .pps     (pps)
);

// File: tb/sns_tod_clock_tb.sv
module sns_tod_clock_tb;
   localparam int unsigned LIMIT = 1000;
   localparam int unsigned HALF  = 500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        pps;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sns_tod_clock #(
      .NS_W (10), .SEC_W (40), .NS_PER_SEC (LIMIT), .HALF_SEC (HALF), .PPS_REG (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .pps (pps)
   );

   typedef struct {
      string       tag;
      int unsigned ns;
      logic [31:0] res;
      logic [39:0] sec;
      logic        pps;
   } exp_t;

   exp_t exp_q[$];

   int unsigned m_ns = 0;
   logic [31:0] m_res = '0;
   logic [39:0] m_sec = '0;
   logic [31:0] m_adj = '0;
   logic [39:0] m_stage = '0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
      end
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   // Driver: one cycle with optional write, then push the expected state.
   task automatic cyc(input string tag, input bit we, input logic [2:0] a, input logic [31:0] d);
      logic [31:0] inc;
      logic [32:0] s33;
      int unsigned nsn;
      exp_t it;
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      if (we && a == 3'd0) begin
         m_ns = d; m_sec = m_stage; m_res = '0;
      end else begin
         inc = m_adj[31] ? (32'h8000_0000 - {1'b0, m_adj[30:0]}) : (32'h8000_0000 + {1'b0, m_adj[30:0]});
         s33 = {1'b0, m_res} + {1'b0, inc};
         m_res = s33[31:0];
         nsn = m_ns + 12 + (s33[32] ? 1 : 0);
         if (nsn >= LIMIT) begin
            nsn = nsn - LIMIT;
            m_sec = m_sec + 40'd1;
         end
         m_ns = nsn;
      end
      if (we && a == 3'd4) m_adj = d;
      if (we && a == 3'd2) m_stage[31:0] = d;
      if (we && a == 3'd3) m_stage[39:32] = d[7:0];
      it.tag = tag; it.ns = m_ns; it.res = m_res; it.sec = m_sec; it.pps = (m_ns < HALF);
      exp_q.push_back(it);
      wr_en = 1'b0;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) cyc(tag, 1'b0, 3'd0, 32'd0);
   endtask

   // Monitor: pop and compare at the falling edge.
   initial begin
      exp_t it;
      logic [31:0] v;
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            peek(3'd0, v); chk(it.tag, "ns", 64'(v), 64'(it.ns));
            peek(3'd1, v); chk(it.tag, "residue", 64'(v), 64'(it.res));
            peek(3'd2, v); chk(it.tag, "sec_lo", 64'(v), 64'(it.sec[31:0]));
            peek(3'd3, v); chk(it.tag, "sec_hi", 64'(v), 64'(it.sec[39:32]));
            chk(it.tag, "pps", 64'(pps), 64'(it.pps));
         end
      end
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      #35;
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         peek(3'(a), v);
         chk("R1", "reset word", 64'(v), 64'd0);
      end
      chk("R1", "reset pps", 64'(pps), 64'd1);
      @(negedge clk);
      #6 rst_n = 1'b1;

      idle("R2", 6);
      cyc("R4", 1'b1, 3'd4, 32'h7FFF_FFFF);
      peek(3'd4, v); chk("R4", "adj readback", 64'(v), 64'h7FFF_FFFF);
      idle("R3", 5);
      cyc("R4", 1'b1, 3'd4, 32'hFFFF_FFFF);
      idle("R3", 5);
      cyc("R3", 1'b1, 3'd4, 32'h4000_0000);
      idle("R3", 4);
      cyc("R3", 1'b1, 3'd4, 32'hC000_0000);
      idle("R3", 4);
      cyc("R7", 1'b1, 3'd2, 32'hFFFF_FFFF);
      cyc("R7", 1'b1, 3'd3, 32'h0000_0000);
      idle("R7", 2);
      cyc("R8", 1'b1, 3'd0, 32'd975);
      idle("R6", 4);
      idle("R5", 3);
      cyc("R9", 1'b1, 3'd0, 32'd470);
      idle("R9", 5);
      idle("R5", 200);
      cyc("R3", 1'b1, 3'd4, 32'h0000_0000);
      idle("R2", 4);
      cyc("R10", 1'b0, 3'd0, 32'd0);
      for (int a = 5; a < 8; a++) begin
         peek(3'(a), v);
         chk("R10", "unmapped read", 64'(v), 64'd0);
      end
      repeat (3) @(negedge clk);
      #8;
      chk("R10", "queue drained", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule